// File: doc/BRIEF.md
# Flat Panel Power Sequencer

This block brings a flat panel up and down in a fixed order. It drives three things: the enable for the panel supply rail, the enable for the panel bias and backlight, and a gate that holds the pixel data and control lines at zero. A single level input, `panel_en`, says which way the sequence should go. High moves the machine toward fully on. Low moves it back toward off.

The machine has four ordered states. Moving up, it first enables the supply, then opens the pixel interface, and last turns on the bias. Moving down, it visits the same states in reverse. This means the bias is always removed first and the supply last, and the interface is driven only while the supply is up.

Each step waits a programmable number of reference ticks. There is one 16-bit gap per pair of neighbouring states, and the same gap is used in both directions. If `panel_en` changes part way through a sequence, the machine turns around from the state it has reached.

Top module: `panel_pwr_seq`

## Requirements
- R1: While reset is held and right after it is released, `seq_state` is 0, and `supply_en`, `bias_en`, `ready`, `pix_data_o` and `pix_ctrl_o` are all 0, with `idle` at 1.
- R2: The encoding of `seq_state` is 0 = off, 1 = supply only, 2 = interface driven, 3 = fully on. `supply_en` is high in states 1, 2 and 3. `bias_en` is high only in state 3. Both enables change on the same clock edge as `seq_state`.
- R3: In states 0 and 1, `pix_data_o` and `pix_ctrl_o` are all zero. In states 2 and 3 they equal `pix_data_i` and `pix_ctrl_i` in the same cycle (default `GATE_REG` = 0).
- R4: `seq_state` changes by exactly one per step. It never rises on an edge where `panel_en` is sampled low, and it never falls on an edge where `panel_en` is sampled high.
- R5: The gap between states 0 and 1 is `gap_supply`, between 1 and 2 is `gap_drive`, and between 2 and 3 is `gap_bias`. Each gap applies in both directions. A step is taken on the first edge at which the number of sampled `ref_tick` pulses in the current dwell reaches the gap. A dwell starts after the edge that entered the state. Ticks on edges where the state does not need to move are not counted.
- R6: A gap of zero makes the step happen on the next clock edge, whether or not `ref_tick` is high.
- R7: A change of `panel_en` restarts the dwell. Counting begins with the tick sampled on the edge where the new level is first seen. A climb that is cut short reverses from the state already reached, and that state is never overshot.
- R8: `ready` is high exactly in state 3, and `idle` is high exactly in state 0.
- R9: While `panel_en` stays low in state 0, `ref_tick` and the gap inputs have no effect: `idle` stays 1 and both enables stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle pulse of the dwell time base |
| panel_en | input | 1 | Requests power-up when high, power-down when low |
| gap_supply | input | DLY_W | Ticks between off and supply-only |
| gap_drive | input | DLY_W | Ticks between supply-only and interface driven |
| gap_bias | input | DLY_W | Ticks between interface driven and fully on |
| pix_data_i | input | DATA_W | Pixel data from the timing generator |
| pix_ctrl_i | input | CTRL_W | Sync and enable lines from the timing generator |
| supply_en | output | 1 | Panel supply rail enable |
| bias_en | output | 1 | Panel bias and backlight enable |
| pix_data_o | output | DATA_W | Gated pixel data toward the panel |
| pix_ctrl_o | output | CTRL_W | Gated control lines toward the panel |
| seq_state | output | 2 | Current sequencer state code |
| ready | output | 1 | High in the fully-on state |
| idle | output | 1 | High in the off state |

## Verification
A wrong state register shows up at the pins in the same cycle: `seq_state`, the two rail enables and the status flags all come from it, and any pairing that is inconsistent breaks an ordering property on the next edge. A dwell counter that runs fast or slow, or that fails to restart when `panel_en` reverses, shows up as a state step one or more edges away from the cycle the bench model predicts. Random gaps, tick density and direction flips make such offsets appear within a few hundred cycles. A gate that leaks data is caught in the first cycle the timing generator drives a non-zero word while the state is 0 or 1.

// File: rtl/pps_pkg.sv
package pps_pkg;

   typedef enum logic [1:0] {
      PS_OFF    = 2'd0,
      PS_SUPPLY = 2'd1,
      PS_DRIVE  = 2'd2,
      PS_ON     = 2'd3
   } pps_state_e;

   localparam int unsigned PPS_STATE_W = 2;
   localparam int unsigned PPS_N_GAPS  = 3;

   function automatic logic pps_rail_on(input pps_state_e s);
      return s != PS_OFF;
   endfunction

   function automatic logic pps_bias_on(input pps_state_e s);
      return s == PS_ON;
   endfunction

   function automatic logic pps_drive_on(input pps_state_e s);
      return (s == PS_DRIVE) || (s == PS_ON);
   endfunction

endpackage

// File: rtl/pps_dwell_timer.sv
module pps_dwell_timer #(
   parameter int unsigned DLY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic             want,
   input  logic [DLY_W-1:0] gap,
   output logic             step
);

   logic [DLY_W-1:0] cnt_q;
   logic [DLY_W-1:0] cnt_eff;
   logic [DLY_W:0]   cnt_inc;
   logic             gap_zero;
   logic             reached;

   always_comb begin
      cnt_eff  = restart ? '0 : cnt_q;
      cnt_inc  = {1'b0, cnt_eff} + {{DLY_W{1'b0}}, 1'b1};
      gap_zero = (gap == '0);
      reached  = tick && (cnt_inc >= {1'b0, gap});
      step     = want && (gap_zero || reached);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (step || !want) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_inc[DLY_W-1:0];
      end else begin
         cnt_q <= cnt_eff;
      end
   end

endmodule

// File: rtl/pps_step_fsm.sv
module pps_step_fsm
   import pps_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       panel_en,
   input  logic       step,
   output pps_state_e state_q,
   output pps_state_e state_nxt,
   output logic       want,
   output logic       restart,
   output logic [1:0] gap_idx
);

   logic en_q;
   logic go_up;
   logic go_dn;

   always_comb begin
      go_up   = panel_en && (state_q != PS_ON);
      go_dn   = !panel_en && (state_q != PS_OFF);
      want    = go_up || go_dn;
      restart = panel_en ^ en_q;
      if (go_up) begin
         gap_idx = state_q;
      end else if (go_dn) begin
         gap_idx = state_q - 2'd1;
      end else begin
         gap_idx = 2'd0;
      end
      state_nxt = state_q;
      if (step && go_up) begin
         state_nxt = pps_state_e'(state_q + 2'd1);
      end else if (step && go_dn) begin
         state_nxt = pps_state_e'(state_q - 2'd1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_OFF;
         en_q    <= 1'b0;
      end else begin
         state_q <= state_nxt;
         en_q    <= panel_en;
      end
   end

endmodule

// File: rtl/pps_rail_ctl.sv
module pps_rail_ctl
   import pps_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  pps_state_e state_nxt,
   output logic       supply_en,
   output logic       bias_en,
   output logic       ready,
   output logic       idle
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         supply_en <= 1'b0;
         bias_en   <= 1'b0;
         ready     <= 1'b0;
         idle      <= 1'b1;
      end else begin
         supply_en <= pps_rail_on(state_nxt);
         bias_en   <= pps_bias_on(state_nxt);
         ready     <= (state_nxt == PS_ON);
         idle      <= (state_nxt == PS_OFF);
      end
   end

endmodule

// File: rtl/pps_out_gate.sv
module pps_out_gate #(
   parameter int unsigned DATA_W   = 24,
   parameter int unsigned CTRL_W   = 3,
   parameter bit          GATE_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open_now,
   input  logic              open_nxt,
   input  logic [DATA_W-1:0] data_i,
   input  logic [CTRL_W-1:0] ctrl_i,
   output logic [DATA_W-1:0] data_o,
   output logic [CTRL_W-1:0] ctrl_o
);

   localparam int unsigned BUS_W = DATA_W + CTRL_W;

   logic [BUS_W-1:0] bus_in;
   logic [BUS_W-1:0] bus_out;
   logic             open_use;
   logic [BUS_W-1:0] bus_use;

   assign bus_in = {ctrl_i, data_i};

   if (GATE_REG) begin : g_reg
      logic             open_q;
      logic [BUS_W-1:0] bus_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            open_q <= 1'b0;
            bus_q  <= '0;
         end else begin
            open_q <= open_nxt;
            bus_q  <= bus_in;
         end
      end
      assign open_use = open_q;
      assign bus_use  = bus_q;
   end else begin : g_comb
      logic unused_nxt;
      assign unused_nxt = open_nxt;
      assign open_use   = open_now;
      assign bus_use    = bus_in;
   end

   for (genvar b = 0; b < BUS_W; b++) begin : g_lane
      assign bus_out[b] = open_use & bus_use[b];
   end

   assign data_o = bus_out[DATA_W-1:0];
   assign ctrl_o = bus_out[BUS_W-1:DATA_W];

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
   import pps_pkg::*;
#(
   parameter int unsigned DLY_W    = 16,
   parameter int unsigned DATA_W   = 24,
   parameter int unsigned CTRL_W   = 3,
   parameter bit          GATE_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              panel_en,
   input  logic [DLY_W-1:0]  gap_supply,
   input  logic [DLY_W-1:0]  gap_drive,
   input  logic [DLY_W-1:0]  gap_bias,
   input  logic [DATA_W-1:0] pix_data_i,
   input  logic [CTRL_W-1:0] pix_ctrl_i,
   output logic              supply_en,
   output logic              bias_en,
   output logic [DATA_W-1:0] pix_data_o,
   output logic [CTRL_W-1:0] pix_ctrl_o,
   output logic [1:0]        seq_state,
   output logic              ready,
   output logic              idle
);

   localparam int unsigned N_GAPS = PPS_N_GAPS;

   if (DLY_W < 1 || DLY_W > 32) begin : g_bad_dly
      $error("panel_pwr_seq: DLY_W must lie in 1..32");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("panel_pwr_seq: DATA_W must be at least 1");
   end
   if (CTRL_W < 1) begin : g_bad_ctrl
      $error("panel_pwr_seq: CTRL_W must be at least 1");
   end

   logic [DLY_W-1:0] gap_tab [N_GAPS];
   logic [DLY_W-1:0] gap_sel;
   logic [1:0]       gap_idx;
   logic             want;
   logic             restart;
   logic             step;
   pps_state_e       state_q;
   pps_state_e       state_nxt;

   assign gap_tab[0] = gap_supply;
   assign gap_tab[1] = gap_drive;
   assign gap_tab[2] = gap_bias;

   always_comb begin
      gap_sel = '0;
      for (int i = 0; i < N_GAPS; i++) begin
         if (gap_idx == i[1:0]) gap_sel = gap_tab[i];
      end
   end

   pps_dwell_timer #(.DLY_W(DLY_W)) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (ref_tick),
      .restart (restart),
      .want    (want),
      .gap     (gap_sel),
      .step    (step)
   );

   pps_step_fsm fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .panel_en  (panel_en),
      .step      (step),
      .state_q   (state_q),
      .state_nxt (state_nxt),
      .want      (want),
      .restart   (restart),
      .gap_idx   (gap_idx)
   );

   pps_rail_ctl rail_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .state_nxt (state_nxt),
      .supply_en (supply_en),
      .bias_en   (bias_en),
      .ready     (ready),
      .idle      (idle)
   );

   pps_out_gate #(
      .DATA_W   (DATA_W),
      .CTRL_W   (CTRL_W),
      .GATE_REG (GATE_REG)
   ) gate_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_now (pps_drive_on(state_q)),
      .open_nxt (pps_drive_on(state_nxt)),
      .data_i   (pix_data_i),
      .ctrl_i   (pix_ctrl_i),
      .data_o   (pix_data_o),
      .ctrl_o   (pix_ctrl_o)
   );

   assign seq_state = state_q;

endmodule

// File: rtl/pps_chk.sv
module pps_chk #(
   parameter int unsigned DATA_W = 24,
   parameter int unsigned CTRL_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              panel_en,
   input logic              supply_en,
   input logic              bias_en,
   input logic [DATA_W-1:0] pix_data_o,
   input logic [CTRL_W-1:0] pix_ctrl_o,
   input logic [1:0]        seq_state,
   input logic              ready,
   input logic              idle
);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (!supply_en && !bias_en && seq_state == 2'd0
                && pix_data_o == '0 && pix_ctrl_o == '0));

   a_r2_bias_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
      bias_en |-> (supply_en && seq_state == 2'd3));

   a_r3_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state < 2'd2) |-> (pix_data_o == '0 && pix_ctrl_o == '0));

   a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(seq_state) |->
         (({1'b0, seq_state} == {1'b0, $past(seq_state)} + 3'd1) ||
          ({1'b0, $past(seq_state)} == {1'b0, seq_state} + 3'd1)));

   a_r4_no_rise_when_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(panel_en) |-> (seq_state <= $past(seq_state)));

   a_r4_no_fall_when_high: assert property (@(posedge clk) disable iff (!rst_n)
      $past(panel_en) |-> (seq_state >= $past(seq_state)));

   a_r8_ready_full: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (bias_en && supply_en && !idle));

endmodule

bind panel_pwr_seq pps_chk #(
   .DATA_W (DATA_W),
   .CTRL_W (CTRL_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .panel_en   (panel_en),
   .supply_en  (supply_en),
   .bias_en    (bias_en),
   .pix_data_o (pix_data_o),
   .pix_ctrl_o (pix_ctrl_o),
   .seq_state  (seq_state),
   .ready      (ready),
   .idle       (idle)
);

// File: tb/panel_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module panel_pwr_seq_tb_top;

   localparam int DLY_W  = 16;
   localparam int DATA_W = 24;
   localparam int CTRL_W = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ref_tick = 1'b0;
   logic              panel_en = 1'b0;
   logic [DLY_W-1:0]  gap_supply = '0;
   logic [DLY_W-1:0]  gap_drive = '0;
   logic [DLY_W-1:0]  gap_bias = '0;
   logic [DATA_W-1:0] pix_data_i = '0;
   logic [CTRL_W-1:0] pix_ctrl_i = '0;
   logic              supply_en, bias_en, ready, idle;
   logic [DATA_W-1:0] pix_data_o;
   logic [CTRL_W-1:0] pix_ctrl_o;
   logic [1:0]        seq_state;

   int checks = 0;
   int errors = 0;

   // reference model state
   int m_st   = 0;
   int m_cnt  = 0;
   bit m_en_q = 1'b0;

   always #10 clk = ~clk;

   panel_pwr_seq #(.DLY_W(DLY_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .panel_en(panel_en),
      .gap_supply(gap_supply), .gap_drive(gap_drive), .gap_bias(gap_bias),
      .pix_data_i(pix_data_i), .pix_ctrl_i(pix_ctrl_i),
      .supply_en(supply_en), .bias_en(bias_en),
      .pix_data_o(pix_data_o), .pix_ctrl_o(pix_ctrl_o),
      .seq_state(seq_state), .ready(ready), .idle(idle));

   task automatic chk(input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int gap_of(input int idx);
      case (idx)
         0:       return int'(gap_supply);
         1:       return int'(gap_drive);
         default: return int'(gap_bias);
      endcase
   endfunction

   // R5 R6 R7: advance the model by one clock edge with the inputs now applied
   task automatic model_step();
      bit up, dn, flip, hit;
      int ceff, g;
      flip = (panel_en != m_en_q);
      ceff = flip ? 0 : m_cnt;
      up   = panel_en && (m_st < 3);
      dn   = !panel_en && (m_st > 0);
      g    = up ? gap_of(m_st) : (dn ? gap_of(m_st - 1) : 0);
      hit  = (g == 0) || (ref_tick && (ceff + 1 >= g));
      if ((up || dn) && hit) begin
         m_st  = up ? m_st + 1 : m_st - 1;
         m_cnt = 0;
      end else if (!(up || dn)) begin
         m_cnt = 0;
      end else begin
         m_cnt = ceff + (ref_tick ? 1 : 0);
      end
      m_en_q = panel_en;
   endtask

   task automatic check_state();
      chk("R2", "seq_state", seq_state, m_st);
      chk("R2", "supply_en", supply_en, (m_st != 0));
      chk("R2", "bias_en", bias_en, (m_st == 3));
      chk("R8", "ready", ready, (m_st == 3));
      chk("R8", "idle", idle, (m_st == 0));
   endtask

   task automatic drive_cycle(input bit en, input bit tk);
      @(negedge clk);
      check_state();
      panel_en   = en;
      ref_tick   = tk;
      pix_data_i = DATA_W'($urandom);
      pix_ctrl_i = CTRL_W'($urandom);
      #1;
      chk("R3", "pix_data_o", pix_data_o, (m_st >= 2) ? longint'(pix_data_i) : 0);
      chk("R3", "pix_ctrl_o", pix_ctrl_o, (m_st >= 2) ? longint'(pix_ctrl_i) : 0);
      model_step();
   endtask

   task automatic peek_after_edge(input string req, input int st_exp);
      @(posedge clk);
      #1;
      chk(req, "seq_state after edge", seq_state, st_exp);
      chk(req, "ready after edge", ready, (st_exp == 3));
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0421));
      pix_data_i = 24'hA5A5A5;
      pix_ctrl_i = 3'b111;
      repeat (3) @(negedge clk);
      // R1: reset state with live inputs on the pixel side
      chk("R1", "seq_state in reset", seq_state, 0);
      chk("R1", "supply_en in reset", supply_en, 0);
      chk("R1", "bias_en in reset", bias_en, 0);
      chk("R1", "idle in reset", idle, 1);
      chk("R1", "ready in reset", ready, 0);
      chk("R1", "pix_data_o in reset", pix_data_o, 0);
      chk("R1", "pix_ctrl_o in reset", pix_ctrl_o, 0);
      rst_n = 1'b1;

      // R9: ticks and gaps ignored while panel_en stays low
      gap_supply = 16'd0; gap_drive = 16'd0; gap_bias = 16'd0;
      for (int i = 0; i < 20; i++) drive_cycle(1'b0, 1'b1);
      chk("R9", "idle after ticks with enable low", idle, 1);
      chk("R9", "supply_en after ticks with enable low", supply_en, 0);

      // R5: gaps 2,3,1 with a tick every cycle, ready after six edges
      gap_supply = 16'd2; gap_drive = 16'd3; gap_bias = 16'd1;
      for (int i = 0; i < 5; i++) drive_cycle(1'b1, 1'b1);
      peek_after_edge("R5", 2);
      drive_cycle(1'b1, 1'b1);
      peek_after_edge("R5", 3);

      // R4 R5: full power-down in reverse order
      for (int i = 0; i < 10; i++) drive_cycle(1'b0, 1'b1);
      chk("R4", "back to off after power-down", seq_state, 0);

      // R6: zero gaps step on every edge with no tick
      gap_supply = 16'd0; gap_drive = 16'd0; gap_bias = 16'd0;
      for (int i = 0; i < 2; i++) drive_cycle(1'b1, 1'b0);
      peek_after_edge("R6", 2);
      drive_cycle(1'b1, 1'b0);
      peek_after_edge("R6", 3);
      for (int i = 0; i < 4; i++) drive_cycle(1'b0, 1'b0);

      // R7: reverse mid-climb from state 2 without reaching state 3
      gap_supply = 16'd1; gap_drive = 16'd1; gap_bias = 16'd4;
      for (int i = 0; i < 3; i++) drive_cycle(1'b1, 1'b1);
      drive_cycle(1'b0, 1'b1);
      peek_after_edge("R7", 1);
      for (int i = 0; i < 6; i++) drive_cycle(1'b0, 1'b1);
      chk("R7", "off after reversal", seq_state, 0);

      // random phase: R2 R3 R4 R5 R7 R8 against the model
      for (int blk = 0; blk < 20; blk++) begin
         bit en;
         gap_supply = DLY_W'($urandom_range(0, 5));
         gap_drive  = DLY_W'($urandom_range(0, 5));
         gap_bias   = DLY_W'($urandom_range(0, 5));
         en = panel_en;
         for (int i = 0; i < 200; i++) begin
            if ($urandom_range(0, 24) == 0) en = !en;
            drive_cycle(en, ($urandom_range(0, 9) < 6));
         end
      end

      drive_cycle(1'b0, 1'b0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule